// File: doc/BRIEF.md
# Phase-Current Polarity Sampler

This block decides, for each of three motor phases, whether the phase current is flowing outward or inward, so that downstream dead-time compensation can choose between the high-side and low-side duty values. Each phase has a digital polarity input from a current comparator. The block also sees the gate states of that phase's upper and lower switches, and two markers from the PWM counter: mid-period and period end. For each phase it keeps one registered polarity bit.

A two-bit source code selects where the polarity comes from. Code 0 makes the block copy three polarity bits written by software. Code 1 samples each comparator once in each switching gap, which is the interval where both gates of that phase are off. Codes 2 and 3 sample all comparators on a counter marker. The marker is mid-period when the counter is center-aligned and period end when it is edge-aligned. The source code takes effect without buffering, so a change applies on the very next clock. Comparator inputs pass through a two-stage synchronizer before any sampling.

Top module: `cs_polarity_sampler`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `pol_o` is all zeros.
- R2: With `src_sel_i` = 2'b00, `pol_o` takes the value of `sw_pol_i` one clock later, and the comparator inputs have no effect.
- R3: With `src_sel_i` = 2'b01, on the first clock where phase i has `gate_hi_i[i]` and `gate_lo_i[i]` both low, after a clock where they were not both low, bit i of `pol_o` loads the synchronized comparator bit on the next clock.
- R4: With `src_sel_i` = 2'b01, a phase samples once per gap: a comparator change later in the same gap does not change `pol_o`.
- R5: With `src_sel_i` = 2'b01, a phase whose gates never reach the both-off state (0 % or 100 % duty) keeps its stored polarity.
- R6: With `src_sel_i` = 2'b1x and `center_i` = 1, all phases sample on a clock with `mid_mark_i` high, and `end_mark_i` is ignored.
- R7: With `src_sel_i` = 2'b1x and `center_i` = 0, all phases sample on a clock with `end_mark_i` high, and `mid_mark_i` is ignored.
- R8: Codes 2'b10 and 2'b11 behave identically.
- R9: In marker modes, sampling takes place whatever the gate states are, including duty extremes.
- R10: A change of `src_sel_i` takes effect on the next clock, in the middle of a period, with no buffering.
- R11: A comparator input reaches the sampling point through two flops. A sample taken on a clock edge therefore uses the comparator value from two edges earlier.
- R12: Outside a sampling event, in modes 2'b01 and 2'b1x, `pol_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | NPH | Comparator polarity per phase (asynchronous) |
| gate_hi_i | input | NPH | Upper switch gate state per phase |
| gate_lo_i | input | NPH | Lower switch gate state per phase |
| mid_mark_i | input | 1 | One-clock pulse at mid-period |
| end_mark_i | input | 1 | One-clock pulse at period end |
| center_i | input | 1 | 1 = center-aligned counter, 0 = edge-aligned |
| src_sel_i | input | 2 | Polarity source code |
| sw_pol_i | input | NPH | Software polarity bits |
| pol_o | output | NPH | Registered polarity per phase |

## Verification
On every cycle, the assertions check the software-copy path, the hold behaviour outside sampling events, and the two-edge sense latency for both gap and marker sampling. Each of these is checked against the checker's own record of the gate gaps and the inputs. Some behaviours show only in the bench's directed scenarios: that a gate pattern with no gap leaves the stored value unchanged, that a comparator change inside one gap is ignored, and that the two marker codes match. A random phase also compares each cycle with a cycle model in the bench, with all four source codes mixed and changed in mid-run.

// File: rtl/cs_pol_pkg.sv
package cs_pol_pkg;
    typedef enum logic [1:0] {
        SRC_SOFT   = 2'b00,
        SRC_GAP    = 2'b01,
        SRC_MARK_A = 2'b10,
        SRC_MARK_B = 2'b11
    } src_e;
endpackage

// File: rtl/cs_sense_sync.sv
module cs_sense_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cs_gap_detect.sv
module cs_gap_detect #(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] gate_hi_i,
    input  logic [NPH-1:0] gate_lo_i,
    output logic [NPH-1:0] gap_start_o
);
    typedef struct packed {
        logic [NPH-1:0] both_off;
    } gap_state_t;

    gap_state_t st_d, st_q;
    logic [NPH-1:0] off_now;

    always_comb begin
        off_now         = ~gate_hi_i & ~gate_lo_i;
        st_d.both_off   = off_now;
        gap_start_o     = off_now & ~st_q.both_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cs_pol_select.sv
module cs_pol_select
    import cs_pol_pkg::*;
#(
    parameter int NPH = 3
) (
    input  src_e           src_i,
    input  logic           center_i,
    input  logic           mid_mark_i,
    input  logic           end_mark_i,
    input  logic [NPH-1:0] sw_pol_i,
    input  logic [NPH-1:0] sense_i,
    input  logic [NPH-1:0] gap_start_i,
    input  logic [NPH-1:0] pol_q_i,
    output logic [NPH-1:0] pol_d_o
);
    logic mark_hit;

    always_comb begin
        mark_hit = center_i ? mid_mark_i : end_mark_i;
    end

    genvar p;
    generate
        for (p = 0; p < NPH; p++) begin : g_phase
            always_comb begin
                unique case (src_i)
                    SRC_SOFT:              pol_d_o[p] = sw_pol_i[p];
                    SRC_GAP:               pol_d_o[p] = gap_start_i[p] ? sense_i[p] : pol_q_i[p];
                    SRC_MARK_A, SRC_MARK_B: pol_d_o[p] = mark_hit ? sense_i[p] : pol_q_i[p];
                    default:               pol_d_o[p] = pol_q_i[p];
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/cs_polarity_sampler.sv
module cs_polarity_sampler
    import cs_pol_pkg::*;
#(
    parameter int NPH         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] cmp_i,
    input  logic [NPH-1:0] gate_hi_i,
    input  logic [NPH-1:0] gate_lo_i,
    input  logic           mid_mark_i,
    input  logic           end_mark_i,
    input  logic           center_i,
    input  logic [1:0]     src_sel_i,
    input  logic [NPH-1:0] sw_pol_i,
    output logic [NPH-1:0] pol_o
);
    typedef struct packed {
        logic [NPH-1:0] pol;
    } top_state_t;

    top_state_t     st_d, st_q;
    logic [NPH-1:0] sense_s;
    logic [NPH-1:0] gap_start;
    logic [NPH-1:0] pol_next;
    src_e           src;

    cs_sense_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (sense_s)
    );

    cs_gap_detect #(.NPH(NPH)) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_hi_i   (gate_hi_i),
        .gate_lo_i   (gate_lo_i),
        .gap_start_o (gap_start)
    );

    cs_pol_select #(.NPH(NPH)) u_sel (
        .src_i       (src),
        .center_i    (center_i),
        .mid_mark_i  (mid_mark_i),
        .end_mark_i  (end_mark_i),
        .sw_pol_i    (sw_pol_i),
        .sense_i     (sense_s),
        .gap_start_i (gap_start),
        .pol_q_i     (st_q.pol),
        .pol_d_o     (pol_next)
    );

    always_comb begin
        src      = src_e'(src_sel_i);
        st_d.pol = pol_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_o = st_q.pol;
endmodule

// File: rtl/cs_polarity_sampler_chk.sv
module cs_polarity_sampler_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] cmp_i,
    input logic [NPH-1:0] gate_hi_i,
    input logic [NPH-1:0] gate_lo_i,
    input logic           mid_mark_i,
    input logic           end_mark_i,
    input logic           center_i,
    input logic [1:0]     src_sel_i,
    input logic [NPH-1:0] sw_pol_i,
    input logic [NPH-1:0] pol_o
);
    logic [NPH-1:0] off_seen_q;
    logic [1:0]     age_q;
    logic [NPH-1:0] gap_new;
    logic           mark_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_seen_q <= '0;
            age_q      <= '0;
        end else begin
            off_seen_q <= ~gate_hi_i & ~gate_lo_i;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    assign gap_new = ~gate_hi_i & ~gate_lo_i & ~off_seen_q;
    assign mark_ev = src_sel_i[1] & (center_i ? mid_mark_i : end_mark_i);

    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> pol_o == '0);

    p_soft_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_i == 2'b00 |=> pol_o == $past(sw_pol_i));

    p_mark_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_ev && age_q == 2'd3) |=> pol_o == $past(cmp_i, 3));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i != 2'b00 && !mark_ev && !(src_sel_i == 2'b01 && gap_new != '0))
        |=> $stable(pol_o));

    genvar p;
    generate
        for (p = 0; p < NPH; p++) begin : g_ph
            p_gap_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (src_sel_i == 2'b01 && gap_new[p] && age_q == 2'd3)
                |=> pol_o[p] == $past(cmp_i[p], 3));
        end
    endgenerate
endmodule

bind cs_polarity_sampler cs_polarity_sampler_chk #(.NPH(NPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_i      (cmp_i),
    .gate_hi_i  (gate_hi_i),
    .gate_lo_i  (gate_lo_i),
    .mid_mark_i (mid_mark_i),
    .end_mark_i (end_mark_i),
    .center_i   (center_i),
    .src_sel_i  (src_sel_i),
    .sw_pol_i   (sw_pol_i),
    .pol_o      (pol_o)
);

// File: tb/cs_polarity_sampler_test.sv
`timescale 1ns/1ps
module cs_polarity_sampler_test;
    localparam int NPH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] cmp_i = '0, gate_hi_i = '1, gate_lo_i = '0, sw_pol_i = '0;
    logic           mid_mark_i = 1'b0, end_mark_i = 1'b0, center_i = 1'b1;
    logic [1:0]     src_sel_i = 2'b00;
    logic [NPH-1:0] pol_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NPH-1:0] m_s0 = '0, m_s1 = '0, m_prev = '0, m_pol = '0;

    always #2.5 clk = ~clk;

    cs_polarity_sampler #(.NPH(NPH)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .gate_hi_i(gate_hi_i),
        .gate_lo_i(gate_lo_i), .mid_mark_i(mid_mark_i), .end_mark_i(end_mark_i),
        .center_i(center_i), .src_sel_i(src_sel_i), .sw_pol_i(sw_pol_i), .pol_o(pol_o)
    );

    function automatic logic [NPH-1:0] next_pol(input logic [1:0] sel, input logic ctr,
            input logic mid, input logic fin, input logic [NPH-1:0] sw,
            input logic [NPH-1:0] sns, input logic [NPH-1:0] start, input logic [NPH-1:0] cur);
        logic hit;
        hit = ctr ? mid : fin;
        if (sel == 2'b00)      return sw;
        else if (sel == 2'b01) return (start & sns) | (~start & cur);
        else                   return hit ? sns : cur;
    endfunction

    always @(posedge clk) begin
        logic [NPH-1:0] off;
        if (!rst_n) begin
            m_s0 = '0; m_s1 = '0; m_prev = '0; m_pol = '0;
        end else begin
            off    = ~gate_hi_i & ~gate_lo_i;
            m_pol  = next_pol(src_sel_i, center_i, mid_mark_i, end_mark_i, sw_pol_i,
                              m_s1, off & ~m_prev, m_pol);
            m_prev = off;
            m_s1   = m_s0;
            m_s0   = cmp_i;
        end
    end

    task automatic check(input string req, input logic [NPH-1:0] act, input logic [NPH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pol_o=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_mid();
        mid_mark_i = 1'b1; cyc(1); mid_mark_i = 1'b0;
    endtask

    task automatic pulse_end();
        end_mark_i = 1'b1; cyc(1); end_mark_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: pol_o=%b expected=completion", pol_o);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(2);
        check("R1 during reset", pol_o, 3'b000);
        rst_n = 1'b1;
        cyc(1);
        check("R1 after release", pol_o, 3'b000);

        // R2: software copy, comparator ignored
        src_sel_i = 2'b00; sw_pol_i = 3'b101; cmp_i = 3'b010;
        cyc(1);
        check("R2 soft copy", pol_o, 3'b101);
        cyc(3);
        check("R2 cmp ignored", pol_o, 3'b101);

        // R3: gap sampling
        gate_hi_i = 3'b111; gate_lo_i = 3'b000; cmp_i = 3'b011; src_sel_i = 2'b01;
        cyc(4);
        check("R12 no gap hold", pol_o, 3'b101);
        gate_hi_i = 3'b000;
        cyc(1);
        check("R3 gap sample", pol_o, 3'b011);
        // R4: change inside the same gap ignored
        cmp_i = 3'b100;
        cyc(4);
        check("R4 once per gap", pol_o, 3'b011);
        // R5: duty extreme, no gap
        gate_lo_i = 3'b111;
        cyc(6);
        check("R5 no gap keeps value", pol_o, 3'b011);
        // only phase 1 gets a gap
        gate_lo_i = 3'b101;
        cyc(1);
        check("R3 single phase gap", pol_o, 3'b001);

        // R6 / R9: center-aligned markers, static gates
        gate_hi_i = 3'b111; gate_lo_i = 3'b000;
        src_sel_i = 2'b10; center_i = 1'b1; cmp_i = 3'b110;
        cyc(3);
        pulse_end();
        check("R6 end mark ignored", pol_o, 3'b001);
        pulse_mid();
        check("R6 R9 mid sample", pol_o, 3'b110);

        // R7 / R8: edge-aligned, code 11
        src_sel_i = 2'b11; center_i = 1'b0; cmp_i = 3'b001;
        cyc(3);
        pulse_mid();
        check("R7 mid mark ignored", pol_o, 3'b110);
        pulse_end();
        check("R7 R8 end sample", pol_o, 3'b001);
        src_sel_i = 2'b10; cmp_i = 3'b010;
        cyc(3);
        pulse_end();
        check("R8 code 10 same", pol_o, 3'b010);

        // R11: cmp change two edges before sample not yet visible
        src_sel_i = 2'b10; center_i = 1'b1; cmp_i = 3'b111;
        cyc(3);
        cmp_i = 3'b000; mid_mark_i = 1'b1;
        cyc(1);
        mid_mark_i = 1'b0;
        check("R11 old value used", pol_o, 3'b111);
        cyc(1);
        pulse_mid();
        check("R11 new value after sync", pol_o, 3'b000);

        // R10: unbuffered method change mid-period
        src_sel_i = 2'b00; sw_pol_i = 3'b110;
        cyc(1);
        check("R10 immediate switch", pol_o, 3'b110);

        // random phase against the cycle model
        for (int i = 0; i < 2000; i++) begin
            cmp_i      = NPH'($urandom);
            gate_hi_i  = NPH'($urandom);
            gate_lo_i  = NPH'($urandom) & ~gate_hi_i;
            mid_mark_i = ($urandom % 6) == 0;
            end_mark_i = ($urandom % 6) == 0;
            sw_pol_i   = NPH'($urandom);
            if ((i % 50) == 0) begin
                src_sel_i = 2'($urandom);
                center_i  = 1'($urandom);
            end
            cyc(1);
            check(src_sel_i == 2'b00 ? "R2 random" :
                  src_sel_i == 2'b01 ? "R3 random" : "R6 R7 random", pol_o, m_pol);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule